// File: doc/BRIEF.md
# Split-Instruction Operand-Latched ALU

This block is an ALU datapath steered by a two-part instruction. A load word names two source registers in an eight-entry register file and says, per source, whether the value is complemented. The possibly complemented values are captured in two operand latches. An execute word names a destination register and five mode flags. It combines the latched operands and writes the result back into the register file.

Because the operands stay latched, an execute word can be issued alone. A run of operations on the same sources then costs no further register selection. A destination may be one of the sources. The write-back does not refresh the latch, so a later lone execute still works on the value that was captured earlier. When a load word and an execute word arrive in the same cycle, the load is applied first and the execute works on the freshly selected operands.

Both instruction ports are valid/ready streams. The block never applies back-pressure: each ready output is held high, and every word presented with its valid high is consumed at that clock edge. The write-back is reported on plain status pins one cycle after the execute is accepted.

Top module: `split_op_alu`

## Requirements
- R1: A load word is laid out as source-A select in bits [7:5], invert-A in bit 4, source-B select in bits [3:1] and invert-B in bit 0. On acceptance each operand latch takes the selected register, bitwise complemented when its invert bit is 1.
- R2: An execute word is laid out as destination select in bits [7:5], OR-mode in bit 4, stored-carry-in in bit 3, carry-in in bit 2, shift-right in bit 1 and popcount in bit 0. The cycle after acceptance, wb_valid is 1 and wb_dst/wb_data show the destination and result, which the register file now holds. With no execute accepted, wb_valid is 0.
- R3: With OR-mode, shift-right and popcount all 0, the result is the low 8 bits of A + B + carry-in, and the carry flag takes bit 8 of that sum.
- R4: With OR-mode 1 and popcount 0, the result is A | B and the carry flag keeps its value.
- R5: Shift-right moves the OR or sum result right by one bit with a zero in bit 7. On an add, the carry flag still takes bit 8 of the unshifted sum.
- R6: With stored-carry-in set, the add uses the current carry flag as its carry-in and ignores the carry-in bit.
- R7: With popcount set, the result is the number of 1 bits in A & B, zero-extended. It overrides OR-mode and shift-right, and the carry flag keeps its value.
- R8: An execute accepted without a load uses the latched operands unchanged, even if their source registers were overwritten since the latch was loaded.
- R9: A load and an execute accepted in the same cycle act load first: the execute uses the newly selected and inverted operands.
- R10: Synchronous reset clears all registers, both operand latches, the carry flag and wb_valid.
- R11: ld_ready and ex_ready are always 1, and a word is consumed on any edge where its valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Load port ready (always 1) |
| ld_word | input | 8 | Load word: source selects and invert bits |
| ex_valid | input | 1 | Execute word valid |
| ex_ready | output | 1 | Execute port ready (always 1) |
| ex_word | input | 8 | Execute word: destination select and mode flags |
| wb_valid | output | 1 | A write-back happened at the last edge |
| wb_dst | output | 3 | Register written |
| wb_data | output | 8 | Value written |
| carry_flag | output | 1 | Stored carry flag |

## Verification
A corrupted operand latch shows up in wb_data on the first execute that reuses it. It then spreads through the register file into later results, so the reference model in the bench diverges within one instruction. A carry flag that drifts appears directly on carry_flag one cycle after the faulty operation. It also appears on the next add that takes its carry-in from the stored flag. Stale-operand reuse after overwriting a source, and same-cycle load plus execute, are exercised explicitly, because an ordering fault is visible only in those cases.

// File: rtl/split_op_alu_pkg.sv
package split_op_alu_pkg;

  localparam int FLAG_W = 5;

  typedef struct packed {
    logic or_mode;
    logic use_cflag;
    logic cin;
    logic shr;
    logic pop;
  } ex_flags_t;

  function automatic ex_flags_t unpack_flags(input logic [FLAG_W-1:0] raw);
    ex_flags_t f;
    f.or_mode   = raw[4];
    f.use_cflag = raw[3];
    f.cin       = raw[2];
    f.shr       = raw[1];
    f.pop       = raw[0];
    return f;
  endfunction

endpackage

// File: rtl/sop_regfile.sv
module sop_regfile #(
  parameter int DATA_W = 8,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  rd_a_sel,
  input  logic [SEL_W-1:0]  rd_b_sel,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] cells [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        cells[g] <= '0;
      end else if (wr_en && (wr_sel == SEL_W'(g))) begin
        cells[g] <= wr_data;
      end
    end
  end

  assign rd_a = cells[rd_a_sel];
  assign rd_b = cells[rd_b_sel];

endmodule

// File: rtl/sop_oplatch.sv
module sop_oplatch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              invert,
  input  logic [DATA_W-1:0] raw_in,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] eff
);

  logic [DATA_W-1:0] conditioned;

  assign conditioned = invert ? ~raw_in : raw_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (load) begin
      held <= conditioned;
    end
  end

  // load-first bypass: a same-cycle execute sees the new operand
  assign eff = load ? conditioned : held;

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(held));

  p_bypass_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !load |-> eff == held);

endmodule

// File: rtl/sop_alu.sv
module sop_alu
  import split_op_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  ex_flags_t         flags,
  input  logic              cflag_q,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              carry_upd
);

  logic              cin_eff;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] masked;
  logic [CNT_W-1:0]  ones;

  assign cin_eff = flags.use_cflag ? cflag_q : flags.cin;
  assign sum     = {1'b0, opa} + {1'b0, opb} + {{DATA_W{1'b0}}, cin_eff};
  assign base    = flags.or_mode ? (opa | opb) : sum[DATA_W-1:0];
  assign shifted = flags.shr ? {1'b0, base[DATA_W-1:1]} : base;
  assign masked  = opa & opb;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_W; i++) begin
      ones = ones + CNT_W'(masked[i]);
    end
  end

  assign result    = flags.pop ? DATA_W'(ones) : shifted;
  assign carry_out = sum[DATA_W];
  assign carry_upd = !flags.or_mode && !flags.pop;

  p_pop_range_r7: assert property (@(posedge clk) disable iff (rst)
    flags.pop |-> result <= DATA_W'(DATA_W));

  p_shr_fill_r5: assert property (@(posedge clk) disable iff (rst)
    (flags.shr && !flags.pop) |-> !result[DATA_W-1]);

  p_or_cover_r4: assert property (@(posedge clk) disable iff (rst)
    (flags.or_mode && !flags.pop && !flags.shr) |-> ((result & opa) == opa));

endmodule

// File: rtl/split_op_alu.sv
module split_op_alu
  import split_op_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_N  = 8,
  localparam int SEL_W = $clog2(REG_N),
  localparam int LD_W  = 2 * SEL_W + 2,
  localparam int EX_W  = SEL_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [LD_W-1:0]   ld_word,
  input  logic              ex_valid,
  output logic              ex_ready,
  input  logic [EX_W-1:0]   ex_word,
  output logic              wb_valid,
  output logic [SEL_W-1:0]  wb_dst,
  output logic [DATA_W-1:0] wb_data,
  output logic              carry_flag
);

  logic [SEL_W-1:0]  a_sel, b_sel, c_sel;
  logic              inv_a, inv_b;
  ex_flags_t         flags;
  logic [DATA_W-1:0] rf_a, rf_b;
  logic [DATA_W-1:0] opa_held, opb_held, opa_eff, opb_eff;
  logic [DATA_W-1:0] alu_res;
  logic              alu_cout, alu_cupd;
  logic              ld_fire, ex_fire;

  assign ld_ready = 1'b1;
  assign ex_ready = 1'b1;
  assign ld_fire  = ld_valid && ld_ready;
  assign ex_fire  = ex_valid && ex_ready;

  assign a_sel = ld_word[2*SEL_W+1 -: SEL_W];
  assign inv_a = ld_word[SEL_W+1];
  assign b_sel = ld_word[SEL_W:1];
  assign inv_b = ld_word[0];
  assign c_sel = ex_word[EX_W-1 -: SEL_W];
  assign flags = unpack_flags(ex_word[FLAG_W-1:0]);

  sop_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_rf (
    .clk(clk), .rst(rst),
    .rd_a_sel(a_sel), .rd_b_sel(b_sel),
    .rd_a(rf_a), .rd_b(rf_b),
    .wr_en(ex_fire), .wr_sel(c_sel), .wr_data(alu_res)
  );

  sop_oplatch #(.DATA_W(DATA_W)) u_lat_a (
    .clk(clk), .rst(rst), .load(ld_fire), .invert(inv_a),
    .raw_in(rf_a), .held(opa_held), .eff(opa_eff)
  );

  sop_oplatch #(.DATA_W(DATA_W)) u_lat_b (
    .clk(clk), .rst(rst), .load(ld_fire), .invert(inv_b),
    .raw_in(rf_b), .held(opb_held), .eff(opb_eff)
  );

  sop_alu #(.DATA_W(DATA_W)) u_alu (
    .clk(clk), .rst(rst),
    .opa(opa_eff), .opb(opb_eff), .flags(flags), .cflag_q(carry_flag),
    .result(alu_res), .carry_out(alu_cout), .carry_upd(alu_cupd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_flag <= 1'b0;
      wb_valid   <= 1'b0;
      wb_dst     <= '0;
      wb_data    <= '0;
    end else begin
      wb_valid <= ex_fire;
      if (ex_fire) begin
        wb_dst  <= c_sel;
        wb_data <= alu_res;
        if (alu_cupd) carry_flag <= alu_cout;
      end
    end
  end

  p_wb_follow_r2: assert property (@(posedge clk) disable iff (rst)
    ex_valid |=> wb_valid);

  p_wb_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> !wb_valid);

  p_wb_dst_r2: assert property (@(posedge clk) disable iff (rst)
    ex_valid |=> wb_dst == $past(ex_word[EX_W-1 -: SEL_W]));

  p_carry_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && (ex_word[4] || ex_word[0])) |=> $stable(carry_flag));

  p_carry_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> $stable(carry_flag));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!wb_valid && !carry_flag));

  p_ready_r11: assert property (@(posedge clk) disable iff (rst)
    ld_ready && ex_ready);

endmodule

// File: tb/tb_split_op_alu.sv
module tb_split_op_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_valid = 1'b0, ex_valid = 1'b0;
  logic [7:0] ld_word = '0, ex_word = '0;
  logic       ld_ready, ex_ready, wb_valid, carry_flag;
  logic [2:0] wb_dst;
  logic [7:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  split_op_alu dut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_word(ld_word),
    .ex_valid(ex_valid), .ex_ready(ex_ready), .ex_word(ex_word),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data),
    .carry_flag(carry_flag)
  );

  // reference state, built from the requirements
  logic [7:0] m_rf [8];
  logic [7:0] m_a, m_b;
  logic       m_c;

  typedef struct packed {
    logic       ldv;
    logic [2:0] a;
    logic       ia;
    logic [2:0] b;
    logic       ib;
    logic       exv;
    logic [2:0] c;
    logic       o, fc, ci, sh, pp;
    logic [3:0] req;
  } vec_t;

  // ldv a ia b ib | exv c or fc cin shr pop | requirement
  localparam vec_t VECS [14] = '{
    '{1'b1, 3'd0, 1'b1, 3'd0, 1'b1, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 R1 R4
    '{1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3}, // R3
    '{1'b1, 3'd1, 1'b0, 3'd2, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3 carry out
    '{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6
    '{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5}, // R5
    '{1'b1, 3'd1, 1'b0, 3'd2, 1'b1, 1'b1, 3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 on OR
    '{1'b1, 3'd6, 1'b0, 3'd1, 1'b0, 1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7}, // R7
    '{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 override
    '{1'b1, 3'd7, 1'b0, 3'd6, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3}, // R3
    '{1'b1, 3'd1, 1'b0, 3'd1, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 overwrite src
    '{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8}, // R8 stale reuse
    '{1'b1, 3'd1, 1'b1, 3'd2, 1'b0, 1'b1, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6}, // R6 R1
    '{1'b1, 3'd3, 1'b0, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 no write
    '{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8}  // R8
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    m_a = '0; m_b = '0; m_c = 1'b0;
  endtask

  task automatic issue(input vec_t v);
    logic [8:0] s;
    logic [7:0] r, base;
    logic       cin;
    int         cnt;
    @(negedge clk);
    ld_valid = v.ldv;
    ld_word  = {v.a, v.ia, v.b, v.ib};
    ex_valid = v.exv;
    ex_word  = {v.c, v.o, v.fc, v.ci, v.sh, v.pp};
    if (v.ldv) begin
      m_a = v.ia ? ~m_rf[v.a] : m_rf[v.a];
      m_b = v.ib ? ~m_rf[v.b] : m_rf[v.b];
    end
    r = '0;
    if (v.exv) begin
      cin  = v.fc ? m_c : v.ci;
      s    = {1'b0, m_a} + {1'b0, m_b} + {8'd0, cin};
      base = v.o ? (m_a | m_b) : s[7:0];
      r    = v.sh ? (base >> 1) : base;
      if (v.pp) begin
        cnt = 0;
        for (int i = 0; i < 8; i++) cnt += int'(m_a[i] & m_b[i]);
        r = 8'(cnt);
      end
      if (!v.o && !v.pp) m_c = s[8];
    end
    @(posedge clk);
    #1;
    chk(2, "wb_valid", {31'd0, wb_valid}, {31'd0, v.exv});
    if (v.exv) begin
      chk(int'(v.req), "wb_data", {24'd0, wb_data}, {24'd0, r});
      chk(2, "wb_dst", {29'd0, wb_dst}, {29'd0, v.c});
      m_rf[v.c] = r;
    end
    chk(int'(v.req), "carry_flag", {31'd0, carry_flag}, {31'd0, m_c});
    ld_valid = 1'b0;
    ex_valid = 1'b0;
  endtask

  function automatic vec_t mk(input logic [2:0] a, input logic [2:0] c, input logic o, input logic [3:0] rq);
    vec_t v;
    v = '0;
    v.ldv = 1'b1; v.a = a; v.b = a; v.exv = 1'b1; v.c = c; v.o = o; v.req = rq;
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs clear while in reset
    chk(10, "wb_valid in reset", {31'd0, wb_valid}, 32'd0);
    chk(10, "carry in reset", {31'd0, carry_flag}, 32'd0);
    // R11: ready held high
    chk(11, "ld_ready", {31'd0, ld_ready}, 32'd1);
    chk(11, "ex_ready", {31'd0, ex_ready}, 32'd1);
    @(negedge clk);
    rst = 1'b0;

    foreach (VECS[i]) issue(VECS[i]);

    // R10: reset mid-run, then every register and latch reads back zero
    @(negedge clk);
    rst = 1'b1;
    ex_valid = 1'b1;
    ex_word = 8'h04;
    @(posedge clk);
    #1;
    chk(10, "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
    chk(10, "carry after reset", {31'd0, carry_flag}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    ex_valid = 1'b0;
    model_reset();
    issue('{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10});
    for (int i = 0; i < 8; i++) issue(mk(3'(i), 3'(i), 1'b1, 4'd10));

    // R11: lone execute with ready high, back-to-back words every cycle
    issue('{1'b1, 3'd0, 1'b1, 3'd0, 1'b0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11});
    issue('{1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd11});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule